// File: doc/BRIEF.md
# Framed Elastic Store Buffer

This block moves byte-wide channel data, organised in frames of 32 timeslots, from a line-side write clock to a system-side read clock. One byte is written on every write clock and one byte is read on every read clock. The storage holds two whole frames (64 entries). A rate mismatch between the two clocks is absorbed by moving the read pointer a whole frame at a time, so frame alignment survives a slip. The write pointer crosses into the read domain as a Gray code through a two-flop synchronizer.

A four-bit control word, sampled in the read-clock domain, selects the mode and issues commands:
- bit 0 selects storage or bypass.
- bit 1 selects a shallow window of four entries, for minimum delay.
- bit 2 re-centres the pointers.
- bit 3 asks for a minimum separation.

Commands act only on a 0-to-1 transition of their bit. In bypass the write-side byte and frame marker go straight to the read-side outputs.

Top module: `frame_elastic_store`

## Requirements
- R1: While control bit 0 (enable) is 0, `rd_data` equals `wr_data` and `rd_fs` equals `wr_fs` at all times.
- R2: While enabled with no command and no slip, each read byte is the byte written just after the previously read one. `rd_fs` is 1 exactly when the byte on `rd_data` was written at timeslot 0 of a frame. The write side raises `wr_fs` only with the byte for timeslot 0; timeslots are counted from the first write after reset, modulo 32.
- R3: When enable rises, the store starts with the read pointer one frame (32 entries) behind the synchronized write pointer. The write-to-read latency is then 32 to 38 write clocks.
- R4: A 0-to-1 transition of control bit 2 (reset) in normal mode puts the read pointer one frame behind the synchronized write pointer. The latency is then 32 to 38 write clocks.
- R5: A 0-to-1 transition of control bit 2 while control bit 1 (minimum delay) is 1 puts the read pointer 2 entries behind the synchronized write pointer. The latency is then 2 to 8 write clocks.
- R6: A 0-to-1 transition of control bit 3 (align) in normal mode, with an observed separation below 16 entries, sets the separation to 16. The latency is then 16 to 22 write clocks.
- R7: An align transition with an observed separation of 16 or more changes nothing: the output stays contiguous and the latency is unchanged.
- R8: Holding control bit 3 high issues no further align. The separation stays as it is until the bit goes low and then high again.
- R9: When the observed separation reaches 0 in normal mode, the read pointer moves back one frame, so the output repeats a frame. `slip` is 1 for exactly one read clock, together with the first repeated byte.
- R10: When the observed separation reaches 60 in normal mode, the read pointer moves forward one frame, so the output skips a frame and `slip` pulses. The separation never exceeds 64.
- R11: During reset `slip` is 0 and the outputs follow the bypass path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write (line-side) clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_data | input | 8 | Byte written each write clock |
| wr_fs | input | 1 | Marks the timeslot-0 byte on the write side |
| rclk | input | 1 | Read (system-side) clock |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| ctrl | input | 4 | Bit 0 enable, bit 1 minimum delay, bit 2 reset command, bit 3 align command |
| rd_data | output | 8 | Byte delivered each read clock |
| rd_fs | output | 1 | Marks the timeslot-0 byte on the read side |
| slip | output | 1 | One-clock pulse on a frame repeat or skip |

## Verification
The bench walks a chain of commands, and each step depends on the one before:
- an align when the separation is already large, which must leave the stream untouched;
- a minimum-delay re-centre;
- a return to normal mode with align still held high, where a level-sensitive align would wrongly jump the latency to 16;
- a fresh align edge, which must then act.

Each byte's value is its own write index, so the bench computes the latency arithmetically, and any off-by-one in a pointer offset moves it out of its window. A slow writer and then a fast writer force both kinds of slip. A slip that moved by anything other than a whole frame would show as a jump other than -32 or +32 and as a frame marker on a byte that is not in timeslot 0.

// File: rtl/es_pkg.sv
package es_pkg;
    localparam int CTRL_W   = 4;
    localparam int CTRL_EN  = 0;
    localparam int CTRL_MIN = 1;
    localparam int CTRL_RST = 2;
    localparam int CTRL_ALN = 3;

    typedef enum logic [1:0] {
        SLIP_NONE,
        SLIP_REPEAT,
        SLIP_SKIP,
        SLIP_RECENTER
    } slip_e;
endpackage

// File: rtl/es_store.sv
module es_store #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          wclk,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/es_gray_sync.sv
module es_gray_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gin,
    output logic [W-1:0] gout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.s1 = gin;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign gout = q.s2;
endmodule

// File: rtl/es_wr_side.sv
module es_wr_side #(
    parameter int AW = 6,
    parameter int PW = 7
) (
    input  logic          wclk,
    input  logic          wrst_n,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
    } wr_st_t;

    wr_st_t q, d;

    always_comb begin
        d.ptr  = q.ptr + PW'(1);
        d.gray = d.ptr ^ (d.ptr >> 1);
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) q <= '0;
        else         q <= d;
    end

    assign waddr = q.ptr[AW-1:0];
    assign wgray = q.gray;

    // R2
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(q.gray ^ $past(q.gray)) <= 1);
endmodule

// File: rtl/es_rd_side.sv
module es_rd_side
    import es_pkg::*;
#(
    parameter int SLOT_W      = 8,
    parameter int FRAME_SLOTS = 32,
    parameter int MIN_DEPTH   = 4,
    parameter int GUARD       = 4,
    parameter int AW          = 6,
    parameter int PW          = 7
) (
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [PW-1:0]     wgray_s,
    input  logic [SLOT_W-1:0] mem_rdata,
    output logic [AW-1:0]     raddr,
    output logic [SLOT_W-1:0] out_data,
    output logic              out_fs,
    output logic              out_slip,
    output logic              out_en
);
    localparam int DEPTH = 2 * FRAME_SLOTS;
    localparam int SW    = $clog2(FRAME_SLOTS);
    localparam logic [PW-1:0] FRAME_P  = PW'(FRAME_SLOTS);
    localparam logic [PW-1:0] HALF_FR  = PW'(FRAME_SLOTS / 2);
    localparam logic [PW-1:0] MIN_P    = PW'(MIN_DEPTH);
    localparam logic [PW-1:0] MIN_HALF = PW'(MIN_DEPTH / 2);
    localparam logic [PW-1:0] HI_MARK  = PW'(DEPTH - GUARD);
    localparam logic [PW-1:0] DEPTH_P  = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0]     rptr;
        logic [CTRL_W-1:0] ctrl_prev;
        logic [SLOT_W-1:0] data;
        logic              fs;
        slip_e             slip;
    } rd_st_t;

    rd_st_t q, d;

    logic [PW-1:0]     wps;
    logic [PW-1:0]     fill;
    logic [PW-1:0]     half;
    logic [PW-1:0]     addr;
    logic [CTRL_W-1:0] rise;
    logic              en, mind;

    always_comb begin
        wps[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wps[i] = wps[i+1] ^ wgray_s[i];
        end
    end

    always_comb begin
        en   = ctrl[CTRL_EN];
        mind = ctrl[CTRL_MIN];
        rise = ctrl & ~q.ctrl_prev;
        fill = wps - q.rptr;
        half = mind ? MIN_HALF : HALF_FR;
        d    = q;
        addr = q.rptr;
        d.slip = SLIP_NONE;
        d.ctrl_prev = ctrl;
        if (!en) begin
            addr = wps - FRAME_P;
        end else if (rise[CTRL_RST]) begin
            addr = wps - (mind ? MIN_HALF : FRAME_P);
        end else if (rise[CTRL_ALN] && fill < half) begin
            addr = wps - half;
        end else if (mind && (fill == '0 || fill >= MIN_P)) begin
            addr   = wps - MIN_HALF;
            d.slip = SLIP_RECENTER;
        end else if (!mind && fill == '0) begin
            addr   = q.rptr - FRAME_P;
            d.slip = SLIP_REPEAT;
        end else if (!mind && fill >= HI_MARK) begin
            addr   = q.rptr + FRAME_P;
            d.slip = SLIP_SKIP;
        end
        d.rptr = addr + PW'(1);
        d.fs   = (addr[SW-1:0] == '0);
        d.data = mem_rdata;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) q <= '{rptr: '0, ctrl_prev: '0, data: '0, fs: 1'b0, slip: SLIP_NONE};
        else         q <= d;
    end

    assign raddr    = addr[AW-1:0];
    assign out_data = q.data;
    assign out_fs   = q.fs;
    assign out_slip = (q.slip != SLIP_NONE);
    assign out_en   = q.ctrl_prev[CTRL_EN];

    // R10
    no_overflow_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        fill <= DEPTH_P);

    // R9
    slip_single_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        out_slip |=> !out_slip);

    // R4
    reset_sep_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        (en && !mind && rise[CTRL_RST]) |=> (fill >= FRAME_P - PW'(1)));

    // R6
    align_sep_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        (en && !mind && rise[CTRL_ALN] && !rise[CTRL_RST]) |=> (fill >= HALF_FR - PW'(1)));
endmodule

// File: rtl/frame_elastic_store.sv
module frame_elastic_store
    import es_pkg::*;
#(
    parameter int SLOT_W      = 8,
    parameter int FRAME_SLOTS = 32,
    parameter int MIN_DEPTH   = 4,
    parameter int GUARD       = 4
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic [SLOT_W-1:0] wr_data,
    input  logic              wr_fs,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [SLOT_W-1:0] rd_data,
    output logic              rd_fs,
    output logic              slip
);
    localparam int DEPTH = 2 * FRAME_SLOTS;
    localparam int AW    = $clog2(DEPTH);
    localparam int PW    = AW + 1;
    localparam int SW    = $clog2(FRAME_SLOTS);

    logic [AW-1:0]     waddr, raddr;
    logic [PW-1:0]     wgray, wgray_s;
    logic [SLOT_W-1:0] mem_rdata, st_data;
    logic              st_fs, st_en;

    es_wr_side #(.AW(AW), .PW(PW)) u_wr (
        .wclk(wclk), .wrst_n(wrst_n), .waddr(waddr), .wgray(wgray)
    );

    es_store #(.W(SLOT_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .wclk(wclk), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    es_gray_sync #(.W(PW)) u_sync (
        .clk(rclk), .rst_n(rrst_n), .gin(wgray), .gout(wgray_s)
    );

    es_rd_side #(
        .SLOT_W(SLOT_W), .FRAME_SLOTS(FRAME_SLOTS), .MIN_DEPTH(MIN_DEPTH),
        .GUARD(GUARD), .AW(AW), .PW(PW)
    ) u_rd (
        .rclk(rclk), .rrst_n(rrst_n), .ctrl(ctrl), .wgray_s(wgray_s),
        .mem_rdata(mem_rdata), .raddr(raddr), .out_data(st_data),
        .out_fs(st_fs), .out_slip(slip), .out_en(st_en)
    );

    assign rd_data = st_en ? st_data : wr_data;
    assign rd_fs   = st_en ? st_fs   : wr_fs;

    // R2
    wr_frame_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_fs |-> (waddr[SW-1:0] == '0));
endmodule

// File: tb/test_frame_elastic_store.sv
`timescale 1ns/1ps
module test_frame_elastic_store;
    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       wrst_n = 1'b0;
    logic       rrst_n = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       wr_fs = 1'b1;
    logic [3:0] ctrl = 4'd0;
    logic [7:0] rd_data;
    logic       rd_fs;
    logic       slip;

    real whalf = 5.0;
    int  n = 0;
    int  checks = 0;
    int  fails = 0;

    frame_elastic_store i_frame_elastic_store (
        .wclk(wclk), .wrst_n(wrst_n), .wr_data(wr_data), .wr_fs(wr_fs),
        .rclk(rclk), .rrst_n(rrst_n), .ctrl(ctrl),
        .rd_data(rd_data), .rd_fs(rd_fs), .slip(slip)
    );

    always #5 rclk = ~rclk;

    initial begin
        #2;
        forever #(whalf) wclk = ~wclk;
    end

    // writer: byte value is its own write index
    initial begin
        @(posedge wrst_n);
        forever begin
            @(posedge wclk);
            #1;
            n = n + 1;
            wr_data = n[7:0];
            wr_fs = (n[4:0] == 5'd0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic window(input int cycles, input int lo, input int hi, input string req);
        int prev;
        int lat;
        prev = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge rclk);
            lat = (n - int'(rd_data)) & 255;
            if (c > 0) chk(rd_data == 8'(prev + 1), "R2 contiguous", int'(rd_data), (prev + 1) & 255);
            chk(rd_fs == (rd_data[4:0] == 5'd0), "R2 frame marker", int'(rd_fs), int'(rd_data[4:0] == 5'd0));
            chk(lat >= lo && lat <= hi, req, lat, lo);
            chk(!slip, "R9 no spurious slip", int'(slip), 0);
            prev = int'(rd_data);
        end
    endtask

    task automatic slip_phase(input int cycles, input bit under, input string req);
        int prev;
        int nslip;
        int expv;
        prev = 0;
        nslip = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge rclk);
            if (c > 0) begin
                if (slip) begin
                    nslip++;
                    expv = under ? ((prev + 1 - 32) & 255) : ((prev + 33) & 255);
                    chk(int'(rd_data) == expv, req, int'(rd_data), expv);
                end else begin
                    chk(rd_data == 8'(prev + 1), "R2 contiguous", int'(rd_data), (prev + 1) & 255);
                end
            end
            chk(rd_fs == (rd_data[4:0] == 5'd0), "R2 frame marker", int'(rd_fs), int'(rd_data[4:0] == 5'd0));
            prev = int'(rd_data);
        end
        chk(nslip > 0, req, nslip, 1);
    endtask

    initial begin
        #1_000_000;
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #20;
        // R11 reset state
        chk(slip == 1'b0, "R11 slip in reset", int'(slip), 0);
        chk(rd_data == wr_data, "R11 bypass in reset", int'(rd_data), int'(wr_data));
        #11;
        wrst_n = 1'b1;
        rrst_n = 1'b1;

        // R1 bypass
        for (int c = 0; c < 40; c++) begin
            @(negedge rclk);
            chk(rd_data == wr_data, "R1 bypass data", int'(rd_data), int'(wr_data));
            chk(rd_fs == wr_fs, "R1 bypass marker", int'(rd_fs), int'(wr_fs));
        end

        // R3 enable
        @(negedge rclk); ctrl[0] = 1'b1;
        repeat (8) @(negedge rclk);
        window(40, 32, 38, "R3 latency after enable");

        // R4 reset command
        @(negedge rclk); ctrl[2] = 1'b1;
        @(negedge rclk); ctrl[2] = 1'b0;
        repeat (6) @(negedge rclk);
        window(40, 32, 38, "R4 latency after reset");

        // R7 align with large separation: no change
        @(negedge rclk); ctrl[3] = 1'b1;
        window(40, 32, 38, "R7 align no-op");

        // R5 minimum-delay reset, align still held
        @(negedge rclk); ctrl[1] = 1'b1; ctrl[2] = 1'b1;
        @(negedge rclk); ctrl[2] = 1'b0;
        repeat (6) @(negedge rclk);
        window(40, 2, 8, "R5 latency in min-delay");

        // R8 back to normal with align still high: no new align
        @(negedge rclk); ctrl[1] = 1'b0;
        window(60, 2, 8, "R8 held align inert");

        // R6 fresh align edge acts
        @(negedge rclk); ctrl[3] = 1'b0;
        @(negedge rclk); ctrl[3] = 1'b1;
        repeat (6) @(negedge rclk);
        window(40, 16, 22, "R6 latency after align");
        @(negedge rclk); ctrl[3] = 1'b0;

        // R9 slow writer: frame repeat
        whalf = 5.5;
        slip_phase(900, 1'b1, "R9 frame repeat");

        // R10 fast writer: frame skip
        whalf = 4.5;
        slip_phase(900, 1'b0, "R10 frame skip");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule